// File: doc/BRIEF.md
# Saturating Accumulator Negation Unit

The unit keeps a pair of 40-bit signed accumulators and carries out one arithmetic operation: it takes one accumulator, forms its two's-complement negative, clamps that value to the signed 40-bit range, and stores it in one of the two accumulators. The source and the destination are chosen independently, so an accumulator can be negated in place or copied negated into the other one.

Each operation refreshes a small set of arithmetic status flags. The zero and negative flags describe the value that was just written. Each accumulator has its own carry and overflow flags, and only the destination's pair is written. Each accumulator also has a sticky overflow flag. It records that an overflow happened and stays set until a dedicated clear input resets it. A direct load port writes accumulator values so that test or setup code can prepare operands.

Top module: `acc_neg_unit`

## Requirements
- R1: While `rst_n` is low, both accumulators and all eight flag bits are zero on the following clock edge.
- R2: When `ld_en` is high at a clock edge, `ld_val` is written into accumulator `ld_sel` (0 or 1). In that cycle `op_go` is ignored: the other accumulator does not change and flag bits 0 to 5 do not change.
- R3: When `op_go` is high and `ld_en` is low, the unit writes the negative of accumulator `src_sel` into accumulator `dst_sel` at that clock edge. The accumulator that is not the destination keeps its value. Any of the four source and destination pairings is allowed.
- R4: Negating the most negative value, 0x80_0000_0000, gives 0x7F_FFFF_FFFF. This is the only input that saturates.
- R5: After an operation, `flag_q[0]` (zero) is 1 exactly when both the low 32 bits and the top 8 bits of the written value are zero.
- R6: After an operation, `flag_q[1]` (negative) equals bit 39 of the written value.
- R7: An operation sets the destination's carry bit (`flag_q[2]` for accumulator 0, `flag_q[3]` for accumulator 1) when the source value is zero and clears it otherwise. The other accumulator's carry bit does not change.
- R8: An operation sets the destination's overflow bit (`flag_q[4]` for accumulator 0, `flag_q[5]` for accumulator 1) when the result saturated and clears it otherwise. The other accumulator's overflow bit does not change.
- R9: The sticky overflow bit (`flag_q[6]` for accumulator 0, `flag_q[7]` for accumulator 1) is set by a saturating operation on that destination. An operation never clears it. It falls only when `sticky_clr[i]` is high. If a saturating operation and a clear hit the same bit in the same cycle, the bit is set.
- R10: When `op_go` and `ld_en` are both low, the accumulators and flag bits 0 to 5 keep their values, whatever the select inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_go | input | 1 | Run one negation in this cycle |
| src_sel | input | 1 | Source accumulator index |
| dst_sel | input | 1 | Destination accumulator index |
| ld_en | input | 1 | Direct load strobe; takes priority over `op_go` |
| ld_sel | input | 1 | Accumulator written by the load |
| ld_val | input | 40 | Value written by the load |
| sticky_clr | input | 2 | Per-accumulator clear of the sticky overflow bit |
| acc0_q | output | 40 | Accumulator 0 |
| acc1_q | output | 40 | Accumulator 1 |
| flag_q | output | 8 | Flags: 0 zero, 1 negative, 3:2 carry, 5:4 overflow, 7:6 sticky overflow |

## Verification
Every result is registered once. A load, an operation or a sticky clear applied before a rising edge shows up on `acc0_q`, `acc1_q` and `flag_q` right after that edge and is still there at the following falling edge. The bench changes inputs only on falling edges and samples outputs one falling edge later, so each check falls exactly one cycle after its stimulus. Checks for values that must hold are made after several idle cycles.

// File: rtl/acc_neg_pkg.sv
// Shared definitions for the accumulator negation unit.
// Assumes exactly two accumulators; the flag layout below is the port layout.
package acc_neg_pkg;

    localparam int NUM_ACC = 2;

    // Status flags, packed so that bit 0 is zero and bit 7 is sticky overflow of acc 1.
    typedef struct packed {
        logic [NUM_ACC-1:0] sticky;
        logic [NUM_ACC-1:0] ovf;
        logic [NUM_ACC-1:0] carry;
        logic               neg;
        logic               zero;
    } neg_flags_t;

endpackage

// File: rtl/acc_sat_negate.sv
// Combinational saturating negation of a signed WIDTH-bit value.
// Assumes WIDTH >= 2; the single saturating input is the most negative value.
module acc_sat_negate #(
    parameter int WIDTH = 40
) (
    input  logic [WIDTH-1:0] src_i,
    output logic [WIDTH-1:0] res_o,
    output logic             sat_o,
    output logic             src_zero_o
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MOST_POS = ~MOST_NEG;

    // Negate, clamping the lone out-of-range case to the largest positive value.
    always_comb begin
        sat_o      = (src_i == MOST_NEG);
        src_zero_o = (src_i == '0);
        res_o      = sat_o ? MOST_POS : (~src_i + WIDTH'(1));
    end

endmodule

// File: rtl/acc_bank.sv
// Two accumulator registers with a direct load port and an operation write port.
// Assumes the caller never raises wr_en while ld_en is high; load is still given priority.
module acc_bank #(
    parameter int WIDTH = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_en,
    input  logic                  ld_sel,
    input  logic [WIDTH-1:0]      ld_val,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [WIDTH-1:0]      wr_val,
    output logic [1:0][WIDTH-1:0] acc_q
);

    for (genvar i = 0; i < acc_neg_pkg::NUM_ACC; i++) begin : g_acc
        // Hold, load or take the operation result for accumulator i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q[i] <= '0;
            end else if (ld_en && (ld_sel == 1'(i))) begin
                acc_q[i] <= ld_val;
            end else if (wr_en && (wr_sel == 1'(i))) begin
                acc_q[i] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/acc_flag_reg.sv
// Status flag register for the negation operation.
// Assumes res_i is the value written to the destination in the same cycle as upd_en.
module acc_flag_reg
    import acc_neg_pkg::*;
#(
    parameter int WIDTH = 40,
    parameter int LOW_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic                dst_sel,
    input  logic [WIDTH-1:0]    res_i,
    input  logic                src_zero_i,
    input  logic                sat_i,
    input  logic [NUM_ACC-1:0]  sticky_clr,
    output neg_flags_t          flags_q
);

    localparam int EXT_W = WIDTH - LOW_W;

    neg_flags_t flags_d;
    logic       res_zero;

    // Zero means both the low word and the extension byte are clear.
    always_comb begin
        res_zero = (res_i[LOW_W-1:0] == '0) && (res_i[WIDTH-1:LOW_W] == EXT_W'(0));
    end

    // Next flags: apply sticky clears first so that a same-cycle set wins.
    always_comb begin
        flags_d        = flags_q;
        flags_d.sticky = flags_q.sticky & ~sticky_clr;
        if (upd_en) begin
            flags_d.zero           = res_zero;
            flags_d.neg            = res_i[WIDTH-1];
            flags_d.carry[dst_sel] = src_zero_i;
            flags_d.ovf[dst_sel]   = sat_i;
            if (sat_i) begin
                flags_d.sticky[dst_sel] = 1'b1;
            end
        end
    end

    // Register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/acc_neg_unit.sv
// Top of the accumulator negation unit: source mux, saturating negator,
// accumulator bank and flag register. Assumes a single clock and synchronous reset.
module acc_neg_unit
    import acc_neg_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_go,
    input  logic             src_sel,
    input  logic             dst_sel,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [ACC_W-1:0] ld_val,
    input  logic [1:0]       sticky_clr,
    output logic [ACC_W-1:0] acc0_q,
    output logic [ACC_W-1:0] acc1_q,
    output logic [7:0]       flag_q
);

    logic [1:0][ACC_W-1:0] acc_q;
    logic [ACC_W-1:0]      src_val;
    logic [ACC_W-1:0]      neg_val;
    logic                  neg_sat;
    logic                  src_zero;
    logic                  op_fire;
    neg_flags_t            flags;

    // Operation fires only when no load claims the cycle.
    always_comb begin
        op_fire = op_go && !ld_en;
        src_val = acc_q[src_sel];
    end

    acc_sat_negate #(.WIDTH(ACC_W)) u_neg (
        .src_i      (src_val),
        .res_o      (neg_val),
        .sat_o      (neg_sat),
        .src_zero_o (src_zero)
    );

    acc_bank #(.WIDTH(ACC_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_sel (ld_sel),
        .ld_val (ld_val),
        .wr_en  (op_fire),
        .wr_sel (dst_sel),
        .wr_val (neg_val),
        .acc_q  (acc_q)
    );

    acc_flag_reg #(.WIDTH(ACC_W), .LOW_W(LOW_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_en     (op_fire),
        .dst_sel    (dst_sel),
        .res_i      (neg_val),
        .src_zero_i (src_zero),
        .sat_i      (neg_sat),
        .sticky_clr (sticky_clr),
        .flags_q    (flags)
    );

    // Drive the flat output ports.
    always_comb begin
        acc0_q = acc_q[0];
        acc1_q = acc_q[1];
        flag_q = flags;
    end

endmodule

// File: rtl/acc_neg_unit_chk.sv
// Temporal checks on the ports of acc_neg_unit, attached by bind.
module acc_neg_unit_chk #(
    parameter int ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_go,
    input logic             src_sel,
    input logic             dst_sel,
    input logic             ld_en,
    input logic             ld_sel,
    input logic [ACC_W-1:0] ld_val,
    input logic [1:0]       sticky_clr,
    input logic [ACC_W-1:0] acc0_q,
    input logic [ACC_W-1:0] acc1_q,
    input logic [7:0]       flag_q
);

    localparam logic [ACC_W-1:0] TOP_POS = {1'b0, {(ACC_W-1){1'b1}}};

    // R2
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> ((($past(ld_sel) ? acc1_q : acc0_q)) == $past(ld_val)));

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && !ld_en) |=> (flag_q[0] == (($past(dst_sel) ? acc1_q : acc0_q) == '0)));

    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && !ld_en) |=> (flag_q[1] == ($past(dst_sel) ? acc1_q[ACC_W-1] : acc0_q[ACC_W-1])));

    // R4
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_go && !ld_en && !dst_sel) |=> (flag_q[4] -> (acc0_q == TOP_POS)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_go && !ld_en) |=> ($stable(acc0_q) && $stable(acc1_q) && $stable(flag_q[5:0])));

    // R9
    sticky_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[6]) |-> $past(sticky_clr[0]));

    // R9
    sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[5]) |-> flag_q[7]);

endmodule

bind acc_neg_unit acc_neg_unit_chk #(.ACC_W(ACC_W)) chk (.*);

// File: tb/acc_neg_unit_test.sv
module acc_neg_unit_test;

    localparam logic [39:0] MINV = 40'h80_0000_0000;
    localparam logic [39:0] MAXV = 40'h7F_FFFF_FFFF;
    localparam logic [39:0] MARK = 40'h12_3456_789A;

    typedef struct packed {
        logic        src;
        logic        dst;
        logic [39:0] val;
        logic [39:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 40'h00_0000_0005, 40'hFF_FFFF_FFFB},
        '{1'b0, 1'b1, 40'h00_0000_0000, 40'h00_0000_0000},
        '{1'b1, 1'b0, 40'hFF_FFFF_FFFF, 40'h00_0000_0001},
        '{1'b1, 1'b1, MINV,             MAXV},
        '{1'b0, 1'b1, MAXV,             40'h80_0000_0001},
        '{1'b1, 1'b0, MINV,             MAXV},
        '{1'b0, 1'b0, 40'h00_0000_0000, 40'h00_0000_0000},
        '{1'b1, 1'b1, 40'h01_0000_0000, 40'hFF_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_go = 1'b0, src_sel = 1'b0, dst_sel = 1'b0;
    logic        ld_en = 1'b0, ld_sel = 1'b0;
    logic [39:0] ld_val = '0;
    logic [1:0]  sticky_clr = '0;
    logic [39:0] acc0_q, acc1_q;
    logic [7:0]  flag_q;

    logic [39:0] m_acc [2];
    logic [7:0]  m_flags;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    acc_neg_unit uut (
        .clk(clk), .rst_n(rst_n), .op_go(op_go), .src_sel(src_sel), .dst_sel(dst_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .sticky_clr(sticky_clr),
        .acc0_q(acc0_q), .acc1_q(acc1_q), .flag_q(flag_q)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " acc0"}, acc0_q, m_acc[0]);
        check({req, " acc1"}, acc1_q, m_acc[1]);
        check({req, " flags"}, 40'(flag_q), 40'(m_flags));
    endtask

    task automatic load(input logic sel, input logic [39:0] val);
        ld_en = 1'b1; ld_sel = sel; ld_val = val;
        @(negedge clk);
        ld_en = 1'b0;
        m_acc[sel] = val;
    endtask

    // Reference flag and result model written from R3 to R9.
    task automatic model_op(input logic s, input logic d, input logic [1:0] clr);
        logic [39:0] v;
        logic [39:0] r;
        logic        sat;
        v = m_acc[s];
        sat = (v == MINV);
        r = sat ? MAXV : (40'd0 - v);
        m_flags[7:6] = m_flags[7:6] & ~clr;
        m_acc[d] = r;
        m_flags[0] = (r == 40'd0);
        m_flags[1] = r[39];
        m_flags[2 + d] = (v == 40'd0);
        m_flags[4 + d] = sat;
        if (sat) m_flags[6 + d] = 1'b1;
    endtask

    task automatic run_op(input logic s, input logic d, input logic [1:0] clr);
        op_go = 1'b1; src_sel = s; dst_sel = d; sticky_clr = clr;
        @(negedge clk);
        op_go = 1'b0; sticky_clr = '0;
        model_op(s, d, clr);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        m_acc[0] = '0; m_acc[1] = '0; m_flags = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        rst_n = 1'b1;
        check_all("R1");

        // Vector table: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 8; i++) begin
            load(!VECS[i].src, MARK);
            load(VECS[i].src, VECS[i].val);
            run_op(VECS[i].src, VECS[i].dst, 2'b00);
            check("R3/R4 result", VECS[i].dst ? acc1_q : acc0_q, VECS[i].exp);
            check_all("R3-R9 vector");
        end

        // R2: load takes priority, op ignored
        load(1'b0, 40'h00_0000_0007);
        ld_en = 1'b1; ld_sel = 1'b1; ld_val = 40'h00_0000_0009;
        op_go = 1'b1; src_sel = 1'b0; dst_sel = 1'b0;
        @(negedge clk);
        ld_en = 1'b0; op_go = 1'b0;
        m_acc[1] = 40'h00_0000_0009;
        check_all("R2 load priority");

        // R10: idle cycles with moving selects
        repeat (3) begin
            src_sel = ~src_sel; dst_sel = ~dst_sel;
            @(negedge clk);
        end
        check_all("R10 idle hold");

        // R9: sticky survives a clean op, then clears per bit
        check("R9 sticky set", 40'(flag_q[7:6]), 40'd3);
        load(1'b0, 40'h00_0000_0003);
        run_op(1'b0, 1'b0, 2'b00);
        check_all("R9 sticky held, R8 ovf cleared");
        run_op(1'b1, 1'b1, 2'b01);
        check_all("R9 sticky clear acc0 only");
        load(1'b1, MINV);
        run_op(1'b1, 1'b1, 2'b10);
        check_all("R9 set wins over clear");
        check("R9 sticky1", 40'(flag_q[7]), 40'd1);

        // R1: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_acc[0] = '0; m_acc[1] = '0; m_flags = '0;
        check_all("R1 reset again");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule